// File: doc/BRIEF.md
# Hashed Requester-ID to Stream-ID Translation Table

This block turns a 16-bit PCIe requester ID (bus, device, function) into an 8-bit local stream ID. The pairs live in a 256-word table. A word's slot is chosen by a CRC-8 of the requester ID. When two IDs land on the same slot, the later one is placed by linear probing. Each occupied word carries a link to the following slot, so a lookup can walk the chain.

Software-side logic issues a clear and then inserts one pair at a time. Each pair is a requester ID and a global stream ID. The block subtracts a configured base from the global ID and keeps the low 8 bits. Lookups then return the local stream ID together with a hit flag.

Inserts and lookups each use a valid/ready handshake, and only one operation is in progress at a time. A clear sweeps every slot, one slot per cycle. A reset performs the same sweep, and `busy` is high while a sweep is pending or running.

Top module: `sid_xlate`

## Requirements
- R1: The home slot of a requester ID is its CRC-8 with polynomial 0x07 and initial value 0, taken MSB first over the high byte and then the low byte (requester ID 0x0100 hashes to 0x15). An ID inserted into an empty home slot is found by a lookup in exactly one probe.
- R2: A table word holds the requester ID in bits [31:16], the local stream ID in bits [15:8] and the link index in bits [7:0]. The local stream ID is (ins_gsid - cfg_sid_base) mod 256, and a hit returns it on rsp_sid.
- R3: An insert probes from the home slot upward, wrapping modulo 256, until it meets a word that is all zero. Each occupied word it passes that has a zero link gets its link set to that word's index plus one. The new word is written with a zero link. ins_ready stays low for exactly P cycles after acceptance, where P is the number of slots probed.
- R4: A lookup checks the home slot, then follows the links. It hits on a requester-ID match. It misses on an all-zero word, or on a mismatching word whose link is zero. rsp_valid pulses for one cycle after P probe cycles, where P is the number of words examined, and lkp_ready stays low until then.
- R5: A lookup examines at most 256 words before it reports.
- R6: A pulse on clr_req raises busy from the next cycle for 256 cycles. During that time both ready outputs are low. Afterwards every slot is zero, so earlier keys miss.
- R7: After reset is released, busy stays high for 255 cycles and is low at the 256th. The table is empty afterwards.
- R8: Only one request is accepted at a time. When both insert and lookup are valid while idle, the insert is taken and lkp_ready is low.
- R9: A word at slot 255 that is passed by an insert gets link 0. A key placed past the wrap is therefore unreachable, and its lookup misses after one probe.
- R10: A clear requested while a lookup is running lets the lookup deliver its correct response. The sweep then follows, and busy drops 257 cycles after the response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; starts a clearing sweep |
| cfg_sid_base | input | GSID_W | Base subtracted from global stream IDs |
| clr_req | input | 1 | One-cycle request to zero the table |
| busy | output | 1 | Clear pending or in progress |
| ins_valid | input | 1 | Insert request valid |
| ins_ready | output | 1 | Insert request accepted this cycle when valid |
| ins_rid | input | 16 | Requester ID to insert |
| ins_gsid | input | GSID_W | Global stream ID to insert |
| lkp_valid | input | 1 | Lookup request valid |
| lkp_ready | output | 1 | Lookup request accepted this cycle when valid |
| lkp_rid | input | 16 | Requester ID to look up |
| rsp_valid | output | 1 | One-cycle lookup result strobe |
| rsp_hit | output | 1 | Lookup found the requester ID |
| rsp_sid | output | 8 | Local stream ID on a hit |

## Verification
The bench builds three-deep collision chains and a key whose home slot sits inside another chain. If the link updates during probing are wrong, the later keys miss or the probe counts come out wrong. It also looks up a colliding key that was never inserted, which catches a walker that stops early or runs past a zero link. Further cases cover the wrap at slot 255, a base subtraction that underflows, an insert and a lookup arriving together, and a clear arriving in the middle of a lookup. The cycle count of every operation is compared against the model, so an extra or missing probe cycle, or a sweep one slot too short, shows up as a timing mismatch.

// File: rtl/sid_tbl_pkg.sv
package sid_tbl_pkg;
    localparam int RID_W    = 16;
    localparam int SID_W    = 8;
    localparam int IDX_W    = 8;
    localparam int DEPTH    = 1 << IDX_W;
    localparam int CNT_W    = IDX_W + 1;
    localparam logic [7:0] CRC_POLY = 8'h07;

    typedef struct packed {
        logic [RID_W-1:0] rid;
        logic [SID_W-1:0] sid;
        logic [IDX_W-1:0] nxt;
    } entry_t;

    typedef enum logic [1:0] {
        ST_CLEAR = 2'd0,
        ST_IDLE  = 2'd1,
        ST_INS   = 2'd2,
        ST_LKP   = 2'd3
    } state_t;

    // Bit-serial CRC-8, MSB first, zero seed; high byte enters first.
    function automatic logic [IDX_W-1:0] crc8_of(input logic [RID_W-1:0] d);
        logic [7:0] c;
        c = '0;
        for (int i = RID_W - 1; i >= 0; i--) begin
            if (c[7] ^ d[i]) c = {c[6:0], 1'b0} ^ CRC_POLY;
            else             c = {c[6:0], 1'b0};
        end
        return c;
    endfunction
endpackage

// File: rtl/sid_hash.sv
module sid_hash
    import sid_tbl_pkg::*;
(
    input  logic [RID_W-1:0] key,
    output logic [IDX_W-1:0] slot
);
    assign slot = crc8_of(key);
endmodule

// File: rtl/sid_store.sv
module sid_store
    import sid_tbl_pkg::*;
(
    input  logic             clk,
    input  logic [IDX_W-1:0] rd_idx,
    output entry_t           rd_data,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  entry_t           wr_data
);
    entry_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_idx] <= wr_data;
    end

    assign rd_data = mem[rd_idx];
endmodule

// File: rtl/sid_walker.sv
module sid_walker
    import sid_tbl_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clr_req,
    input  logic             ins_valid,
    input  logic [RID_W-1:0] ins_rid,
    input  logic [SID_W-1:0] ins_sid,
    input  logic [IDX_W-1:0] ins_home,
    input  logic             lkp_valid,
    input  logic [RID_W-1:0] lkp_rid,
    input  logic [IDX_W-1:0] lkp_home,
    input  entry_t           rd_data,
    output logic             ins_ready,
    output logic             lkp_ready,
    output logic             busy,
    output logic [IDX_W-1:0] rd_idx,
    output logic             wr_en,
    output logic [IDX_W-1:0] wr_idx,
    output entry_t           wr_data,
    output logic             rsp_valid,
    output logic             rsp_hit,
    output logic [SID_W-1:0] rsp_sid
);
    state_t           state;
    logic [IDX_W-1:0] idx;
    logic [IDX_W-1:0] idx_inc;
    logic [CNT_W-1:0] steps;
    logic [RID_W-1:0] key_rid;
    logic [SID_W-1:0] key_sid;
    logic             clr_pend;
    logic             slot_free;
    logic             key_match;
    logic             last_step;

    assign idx_inc   = idx + 1'b1;
    assign slot_free = (rd_data == '0);
    assign key_match = !slot_free && (rd_data.rid == key_rid);
    assign last_step = (steps == CNT_W'(DEPTH - 1));

    assign busy      = (state == ST_CLEAR) || clr_pend;
    assign ins_ready = (state == ST_IDLE) && !clr_pend && !clr_req;
    assign lkp_ready = ins_ready && !ins_valid;
    assign rd_idx    = idx;
    assign wr_idx    = idx;

    always_comb begin
        wr_en   = 1'b0;
        wr_data = '0;
        case (state)
            ST_CLEAR: wr_en = 1'b1;
            ST_INS: begin
                if (slot_free) begin
                    wr_en   = 1'b1;
                    wr_data = '{rid: key_rid, sid: key_sid, nxt: '0};
                end else if (rd_data.nxt == '0) begin
                    wr_en   = 1'b1;
                    wr_data = '{rid: rd_data.rid, sid: rd_data.sid, nxt: idx_inc};
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_CLEAR;
            idx       <= '0;
            steps     <= '0;
            key_rid   <= '0;
            key_sid   <= '0;
            clr_pend  <= 1'b0;
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_sid   <= '0;
        end else begin
            rsp_valid <= 1'b0;
            if (clr_req) clr_pend <= 1'b1;
            case (state)
                ST_CLEAR: begin
                    idx <= idx_inc;
                    if (idx == IDX_W'(DEPTH - 1)) state <= ST_IDLE;
                end
                ST_IDLE: begin
                    steps <= '0;
                    if (clr_req || clr_pend) begin
                        state    <= ST_CLEAR;
                        idx      <= '0;
                        clr_pend <= 1'b0;
                    end else if (ins_valid) begin
                        state   <= ST_INS;
                        idx     <= ins_home;
                        key_rid <= ins_rid;
                        key_sid <= ins_sid;
                    end else if (lkp_valid) begin
                        state   <= ST_LKP;
                        idx     <= lkp_home;
                        key_rid <= lkp_rid;
                    end
                end
                ST_INS: begin
                    if (slot_free) begin
                        state <= ST_IDLE;
                    end else begin
                        idx   <= idx_inc;
                        steps <= steps + 1'b1;
                        if (last_step) state <= ST_IDLE;
                    end
                end
                ST_LKP: begin
                    if (key_match) begin
                        state     <= ST_IDLE;
                        rsp_valid <= 1'b1;
                        rsp_hit   <= 1'b1;
                        rsp_sid   <= rd_data.sid;
                    end else if (slot_free || rd_data.nxt == '0 || last_step) begin
                        state     <= ST_IDLE;
                        rsp_valid <= 1'b1;
                        rsp_hit   <= 1'b0;
                        rsp_sid   <= '0;
                    end else begin
                        idx   <= rd_data.nxt;
                        steps <= steps + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Checker counters for the bounded windows.
    logic [CNT_W-1:0] lkp_run;
    logic [CNT_W-1:0] clr_run;
    always_ff @(posedge clk) begin
        if (rst) begin
            lkp_run <= '0;
            clr_run <= '0;
        end else begin
            lkp_run <= (state == ST_LKP)   ? lkp_run + 1'b1 : '0;
            clr_run <= (state == ST_CLEAR) ? clr_run + 1'b1 : '0;
        end
    end

    assert_walk_bound_R5: assert property (@(posedge clk) disable iff (rst)
        lkp_run <= CNT_W'(DEPTH));

    assert_clear_len_R6: assert property (@(posedge clk) disable iff (rst)
        clr_run <= CNT_W'(DEPTH));

    assert_stall_busy_R6: assert property (@(posedge clk) disable iff (rst)
        busy |-> (!ins_ready && !lkp_ready));

    assert_rsp_pulse_R4: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);

    assert_rsp_from_walk_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(rsp_valid) |-> $past(state == ST_LKP));

    assert_link_keeps_R3: assert property (@(posedge clk) disable iff (rst)
        (state == ST_INS && wr_en && !slot_free) |->
            (wr_data.rid == rd_data.rid && wr_data.sid == rd_data.sid));

    assert_single_accept_R8: assert property (@(posedge clk) disable iff (rst)
        !(ins_valid && ins_ready && lkp_valid && lkp_ready));
endmodule

// File: rtl/sid_xlate.sv
module sid_xlate
    import sid_tbl_pkg::*;
#(
    parameter int GSID_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [GSID_W-1:0] cfg_sid_base,
    input  logic              clr_req,
    output logic              busy,
    input  logic              ins_valid,
    output logic              ins_ready,
    input  logic [RID_W-1:0]  ins_rid,
    input  logic [GSID_W-1:0] ins_gsid,
    input  logic              lkp_valid,
    output logic              lkp_ready,
    input  logic [RID_W-1:0]  lkp_rid,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [SID_W-1:0]  rsp_sid
);
    localparam int NPORT = 2;

    logic [RID_W-1:0] keys  [NPORT];
    logic [IDX_W-1:0] homes [NPORT];
    logic [SID_W-1:0] ins_sid;
    logic [IDX_W-1:0] rd_idx;
    logic [IDX_W-1:0] wr_idx;
    logic             wr_en;
    entry_t           rd_data;
    entry_t           wr_data;

    assign keys[0] = ins_rid;
    assign keys[1] = lkp_rid;
    assign ins_sid = SID_W'(ins_gsid - cfg_sid_base);

    for (genvar g = 0; g < NPORT; g++) begin : g_hash
        sid_hash u_hash (
            .key  (keys[g]),
            .slot (homes[g])
        );
    end

    sid_store u_store (
        .clk     (clk),
        .rd_idx  (rd_idx),
        .rd_data (rd_data),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data)
    );

    sid_walker u_walk (
        .clk       (clk),
        .rst       (rst),
        .clr_req   (clr_req),
        .ins_valid (ins_valid),
        .ins_rid   (ins_rid),
        .ins_sid   (ins_sid),
        .ins_home  (homes[0]),
        .lkp_valid (lkp_valid),
        .lkp_rid   (lkp_rid),
        .lkp_home  (homes[1]),
        .rd_data   (rd_data),
        .ins_ready (ins_ready),
        .lkp_ready (lkp_ready),
        .busy      (busy),
        .rd_idx    (rd_idx),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_data   (wr_data),
        .rsp_valid (rsp_valid),
        .rsp_hit   (rsp_hit),
        .rsp_sid   (rsp_sid)
    );
endmodule

// File: tb/sim_sid_xlate.sv
module sim_sid_xlate;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] cfg_sid_base = 16'h1d80;
    logic        clr_req = 1'b0;
    logic        busy;
    logic        ins_valid = 1'b0;
    logic        ins_ready;
    logic [15:0] ins_rid = '0;
    logic [15:0] ins_gsid = '0;
    logic        lkp_valid = 1'b0;
    logic        lkp_ready;
    logic [15:0] lkp_rid = '0;
    logic        rsp_valid;
    logic        rsp_hit;
    logic [7:0]  rsp_sid;

    int total = 0;
    int bad = 0;
    logic [31:0] mtbl [256];

    always #4 clk = ~clk;

    sid_xlate #(.GSID_W(16)) u0 (
        .clk(clk), .rst(rst), .cfg_sid_base(cfg_sid_base), .clr_req(clr_req),
        .busy(busy), .ins_valid(ins_valid), .ins_ready(ins_ready),
        .ins_rid(ins_rid), .ins_gsid(ins_gsid), .lkp_valid(lkp_valid),
        .lkp_ready(lkp_ready), .lkp_rid(lkp_rid), .rsp_valid(rsp_valid),
        .rsp_hit(rsp_hit), .rsp_sid(rsp_sid)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Byte-wise CRC-8 (poly 0x07, seed 0), high byte first.
    function automatic logic [7:0] bcrc(input logic [15:0] rid);
        logic [7:0] c;
        logic [7:0] bytes [2];
        bytes[0] = rid[15:8];
        bytes[1] = rid[7:0];
        c = 8'h00;
        for (int b = 0; b < 2; b++) begin
            c = c ^ bytes[b];
            for (int k = 0; k < 8; k++)
                c = c[7] ? ((c << 1) ^ 8'h07) : (c << 1);
        end
        return c;
    endfunction

    function automatic logic [15:0] find_rid(input logic [7:0] h, input int start);
        for (int r = start; r < 65536; r++)
            if (bcrc(16'(r)) == h) return 16'(r);
        return 16'h0;
    endfunction

    function automatic void model_clear();
        for (int i = 0; i < 256; i++) mtbl[i] = 32'h0;
    endfunction

    function automatic int model_insert(input logic [15:0] rid, input logic [7:0] sid);
        int h = int'(bcrc(rid));
        for (int p = 1; p <= 256; p++) begin
            if (mtbl[h] == 32'h0) begin
                mtbl[h] = {rid, sid, 8'h00};
                return p;
            end
            if (mtbl[h][7:0] == 8'h00) mtbl[h][7:0] = 8'((h + 1) % 256);
            h = (h + 1) % 256;
        end
        return 256;
    endfunction

    function automatic int model_lookup(input logic [15:0] rid, output logic hit,
                                        output logic [7:0] sid);
        int h = int'(bcrc(rid));
        hit = 1'b0;
        sid = 8'h00;
        for (int p = 1; p <= 256; p++) begin
            if (mtbl[h] == 32'h0) return p;
            if (mtbl[h][31:16] == rid) begin
                hit = 1'b1;
                sid = mtbl[h][15:8];
                return p;
            end
            if (mtbl[h][7:0] == 8'h00) return p;
            h = int'(mtbl[h][7:0]);
        end
        return 256;
    endfunction

    task automatic do_insert(input string req, input logic [15:0] rid,
                             input logic [15:0] gsid, input bit with_lkp,
                             input logic [15:0] other_rid);
        int p;
        logic [7:0] esid;
        @(negedge clk);
        esid = 8'(gsid - cfg_sid_base);
        p = model_insert(rid, esid);
        ins_rid = rid;
        ins_gsid = gsid;
        ins_valid = 1'b1;
        if (with_lkp) begin
            lkp_rid = other_rid;
            lkp_valid = 1'b1;
            #1;
            chk(req, "lkp_ready with insert pending", {31'h0, lkp_ready}, 32'h0);
        end
        chk(req, "ins_ready before insert", {31'h0, ins_ready}, 32'h1);
        @(posedge clk);
        for (int k = 1; k <= p + 1; k++) begin
            @(negedge clk);
            if (k == 1) begin
                ins_valid = 1'b0;
                lkp_valid = 1'b0;
            end
            chk(req, "no response during insert", {31'h0, rsp_valid}, 32'h0);
            chk(req, "ins_ready during insert", {31'h0, ins_ready},
                (k <= p) ? 32'h0 : 32'h1);
        end
    endtask

    // clr_at: negedge index (1-based) after acceptance at which to pulse clr_req; 0 = none.
    task automatic do_lookup(input string req, input logic [15:0] rid, input int clr_at);
        int p;
        logic ehit;
        logic [7:0] esid;
        @(negedge clk);
        p = model_lookup(rid, ehit, esid);
        lkp_rid = rid;
        lkp_valid = 1'b1;
        chk(req, "lkp_ready before lookup", {31'h0, lkp_ready}, 32'h1);
        @(posedge clk);
        for (int k = 1; k <= p + 1; k++) begin
            @(negedge clk);
            if (k == 1) lkp_valid = 1'b0;
            clr_req = (k == clr_at);
            if (k <= p) begin
                chk(req, "rsp_valid during walk", {31'h0, rsp_valid}, 32'h0);
                chk(req, "lkp_ready during walk", {31'h0, lkp_ready}, 32'h0);
            end else begin
                chk(req, "rsp_valid at end", {31'h0, rsp_valid}, 32'h1);
                chk(req, "rsp_hit", {31'h0, rsp_hit}, {31'h0, ehit});
                if (ehit) chk(req, "rsp_sid", {24'h0, rsp_sid}, {24'h0, esid});
                if (clr_at == 0)
                    chk(req, "lkp_ready after walk", {31'h0, lkp_ready}, 32'h1);
                else
                    chk(req, "busy after walk with clear", {31'h0, busy}, 32'h1);
            end
        end
        clr_req = 1'b0;
        if (clr_at != 0) begin
            model_clear();
            for (int j = 1; j <= 257; j++) begin
                @(negedge clk);
                if (j < 257 && busy !== 1'b1)
                    chk(req, "busy during deferred sweep", {31'h0, busy}, 32'h1);
                if (j == 257) chk(req, "busy after deferred sweep", {31'h0, busy}, 32'h0);
            end
        end
    endtask

    task automatic do_clear(input string req);
        @(negedge clk);
        clr_req = 1'b1;
        @(posedge clk);
        model_clear();
        for (int k = 1; k <= 257; k++) begin
            @(negedge clk);
            if (k == 1) clr_req = 1'b0;
            if (k == 1 || k == 256) begin
                chk(req, "busy during sweep", {31'h0, busy}, 32'h1);
                chk(req, "ins_ready during sweep", {31'h0, ins_ready}, 32'h0);
                chk(req, "lkp_ready during sweep", {31'h0, lkp_ready}, 32'h0);
            end else if (k < 256 && busy !== 1'b1) begin
                chk(req, "busy during sweep", {31'h0, busy}, 32'h1);
            end
            if (k == 257) chk(req, "busy after sweep", {31'h0, busy}, 32'h0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [15:0] c1, c2, c3, d, m, e, a, b;

        // R7: reset sweep
        model_clear();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        for (int k = 1; k <= 256; k++) begin
            @(negedge clk);
            if (k == 1 || k == 255) chk("R7", "busy during reset sweep", {31'h0, busy}, 32'h1);
            if (k == 256) chk("R7", "busy after reset sweep", {31'h0, busy}, 32'h0);
        end
        chk("R7", "rsp_valid idle", {31'h0, rsp_valid}, 32'h0);

        // R1: hash vector and home-slot placement
        chk("R1", "crc of 0100", {24'h0, bcrc(16'h0100)}, 32'h15);
        do_insert("R1", 16'h0100, 16'h1d81, 1'b0, 16'h0);
        do_lookup("R1", 16'h0100, 0);
        e = find_rid(8'h15, 16'h0101);
        do_insert("R1", e, 16'h1d90, 1'b0, 16'h0);
        do_lookup("R1", e, 0);

        // R4: miss on empty home slot
        do_lookup("R4", find_rid(8'h80, 16'h1000), 0);

        // R3: collision chain and a key whose home slot lies inside it
        c1 = find_rid(8'h40, 16'h1000);
        c2 = find_rid(8'h40, int'(c1) + 1);
        c3 = find_rid(8'h40, int'(c2) + 1);
        d  = find_rid(8'h41, 16'h1000);
        do_insert("R3", c1, 16'h1d82, 1'b0, 16'h0);
        do_insert("R3", c2, 16'h1d83, 1'b0, 16'h0);
        do_insert("R3", c3, 16'h1d84, 1'b0, 16'h0);
        do_insert("R3", d,  16'h1d85, 1'b0, 16'h0);
        do_lookup("R3", c1, 0);
        do_lookup("R3", c2, 0);
        do_lookup("R3", c3, 0);
        do_lookup("R3", d, 0);

        // R4: miss at end of chain
        m = find_rid(8'h40, int'(c3) + 1);
        do_lookup("R4", m, 0);

        // R2: base subtraction wraps to 8 bits
        do_insert("R2", 16'h0a0b, 16'h1c7f, 1'b0, 16'h0);
        do_lookup("R2", 16'h0a0b, 0);

        // R8: insert wins over a simultaneous lookup
        do_insert("R8", 16'h3344, 16'h1d99, 1'b1, 16'h0100);
        do_lookup("R8", 16'h3344, 0);

        // R6: clear empties the table
        do_clear("R6");
        do_lookup("R6", 16'h0100, 0);
        do_lookup("R6", c2, 0);

        // R9: wrap at slot 255
        a = find_rid(8'hff, 16'h1000);
        b = find_rid(8'hff, int'(a) + 1);
        do_insert("R9", a, 16'h1da0, 1'b0, 16'h0);
        do_insert("R9", b, 16'h1da1, 1'b0, 16'h0);
        do_lookup("R9", a, 0);
        do_lookup("R9", b, 0);

        // R10: clear requested mid-walk
        do_clear("R10");
        do_insert("R10", c1, 16'h1d82, 1'b0, 16'h0);
        do_insert("R10", c2, 16'h1d83, 1'b0, 16'h0);
        do_lookup("R10", c2, 1);
        do_lookup("R10", c1, 0);

        // R5: worst-case lookups here stay well under the bound
        do_lookup("R5", m, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule